// File: doc/BRIEF.md
# Light-Sensor I2C Register Target

This block is an I2C target that holds the settings, conversion result and alarm thresholds of an ambient light sensor front end. The bus pins SCL and SDA are oversampled in the system clock domain. SDA is driven open-drain: the block only ever pulls the line low, by raising an output enable. A host writes by sending the device address with a write bit, then a one-byte register pointer, then any number of data bytes. It reads by sending the device address with a read bit. The read may follow a repeated START that comes after a pointer write.

The register fields are exported as plain ports for the measurement and alarm logic. The alarm logic raises the interrupt flag through a set input. The measurement logic loads a new 16-bit result through a valid strobe. Whenever the host finishes fetching the eight bits of the first control register, the block emits a one-cycle clear strobe, and the stored flag drops.

Top module: `lux_i2c_regfile`

## Requirements
- R1: The block acknowledges only an address byte whose upper seven bits equal `DEV_ADDR` (default 7'h44). On a mismatch it drives SDA for no further bit until the next START.
- R2: A write is START, address with bit 0 = 0, pointer byte, then data bytes. Every bit goes MSB first, and each byte is acknowledged in its ninth SCL clock.
- R3: The pointer uses its low three bits and advances by one, wrapping 7 to 0, after every data byte, whether written or read.
- R4: Register 0 holds the mode in bits 7:5, the interrupt flag in bit 2 and the persist count in bits 1:0. Bits 4:3 read 0, and bit 2 cannot be written from the bus.
- R5: Register 1 holds the resolution in bits 3:2 and the range in bits 1:0. Bits 7:4 read 0.
- R6: Registers 2 and 3 return the low and high bytes of the result captured on `result_vld_i`. Bus writes to them have no effect.
- R7: Registers 4/5 form the low threshold and registers 6/7 the high threshold, each with the low byte at the lower address.
- R8: After reset, registers 0 to 5 read 00h and registers 6 and 7 read FFh.
- R9: A read byte is driven MSB first. SDA is released for the host's acknowledge slot, and a host NACK ends driving until the next START.
- R10: Completing the eight data bits of a read of register 0 gives a single-cycle `flag_clr_o` pulse, and the flag clears one cycle later. `flag_set_i` sets the flag and wins over a simultaneous clear.
- R11: SDA is sampled on rising SCL, and `sda_oe_o` changes only while SCL is low.
- R12: START and STOP are detected on the synchronised pins. A repeated START restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock pin |
| sda_i | input | 1 | Bus data pin (resolved line) |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| result_i | input | 16 | Conversion result from the measurement logic |
| result_vld_i | input | 1 | Capture strobe for `result_i` |
| flag_set_i | input | 1 | Sets the interrupt flag |
| op_mode_o | output | 3 | Operating mode field |
| persist_o | output | 2 | Persist count field |
| adc_res_o | output | 2 | Resolution field |
| lux_range_o | output | 2 | Range field |
| thr_lo_o | output | 16 | Low threshold |
| thr_hi_o | output | 16 | High threshold |
| irq_flag_o | output | 1 | Stored interrupt flag |
| flag_clr_o | output | 1 | Clear strobe after a read of register 0 |

## Verification
Pin edges reach the engine three system cycles after they occur: two synchroniser flops, then the edge-detect register. A written byte therefore lands in its register about four cycles after the eighth falling SCL, and the clear strobe is due at the same point of a register-0 read. The bench holds each SCL phase for 20 system cycles, so it samples acknowledge and data bits in the middle of the high phase. It compares the exported fields against its model only on idle-bus clocks, well after every update is due. It counts clear pulses across each whole read and matches them against the number of register-0 bytes fetched.

// File: rtl/lux_i2c_pkg.sv
package lux_i2c_pkg;

    localparam int REG_COUNT = 8;
    localparam int PTR_W     = $clog2(REG_COUNT);
    localparam int BYTE_W    = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_PTR,
        PH_WR,
        PH_RD
    } phase_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic [2:0]  mode;
        logic        flag;
        logic [1:0]  persist;
        logic [1:0]  res;
        logic [1:0]  rng;
        logic [15:0] result;
        logic [15:0] thr_lo;
        logic [15:0] thr_hi;
    } regbank_t;

    function automatic regbank_t bank_reset();
        regbank_t r;
        r        = '0;
        r.thr_hi = 16'hFFFF;
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] bank_read(regbank_t r, logic [PTR_W-1:0] idx);
        logic [BYTE_W-1:0] v;
        case (idx)
            3'd0:    v = {r.mode, 2'b00, r.flag, r.persist};
            3'd1:    v = {4'b0000, r.res, r.rng};
            3'd2:    v = r.result[7:0];
            3'd3:    v = r.result[15:8];
            3'd4:    v = r.thr_lo[7:0];
            3'd5:    v = r.thr_lo[15:8];
            3'd6:    v = r.thr_hi[7:0];
            default: v = r.thr_hi[15:8];
        endcase
        return v;
    endfunction

    function automatic regbank_t bank_write(regbank_t r, logic [PTR_W-1:0] idx,
                                            logic [BYTE_W-1:0] d);
        regbank_t n;
        n = r;
        case (idx)
            3'd0: begin
                n.mode    = d[7:5];
                n.persist = d[1:0];
            end
            3'd1: begin
                n.res = d[3:2];
                n.rng = d[1:0];
            end
            3'd4:    n.thr_lo[7:0]  = d;
            3'd5:    n.thr_lo[15:8] = d;
            3'd6:    n.thr_hi[7:0]  = d;
            3'd7:    n.thr_hi[15:8] = d;
            default: n = r;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/lux_i2c_sync.sv
module lux_i2c_sync
    import lux_i2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev_o.scl_rise = scl_s & ~scl_q;
        ev_o.scl_fall = ~scl_s & scl_q;
        ev_o.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev_o.sda      = sda_s;
    end
endmodule

// File: rtl/lux_i2c_engine.sv
module lux_i2c_engine
    import lux_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h44
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev_i,
    input  logic [BYTE_W-1:0] rd_byte_i,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_idx_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              clr_o,
    output logic              sda_oe_o
);
    localparam logic [3:0] LAST_BIT = 4'd8;

    phase_e            ph;
    logic [3:0]        bitcnt;
    logic              in_ack;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic              rw;
    logic              nack;
    logic [PTR_W-1:0]  ptr;

    assign ptr_o     = ptr;
    assign wr_data_o = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            bitcnt   <= '0;
            in_ack   <= 1'b0;
            shreg    <= '0;
            tx       <= '0;
            rw       <= 1'b0;
            nack     <= 1'b1;
            ptr      <= '0;
            wr_en_o  <= 1'b0;
            wr_idx_o <= '0;
            clr_o    <= 1'b0;
            sda_oe_o <= 1'b0;
        end else begin
            wr_en_o <= 1'b0;
            clr_o   <= 1'b0;
            if (ev_i.start) begin
                ph       <= PH_ADDR;
                bitcnt   <= '0;
                in_ack   <= 1'b0;
                sda_oe_o <= 1'b0;
            end else if (ev_i.stop) begin
                ph       <= PH_IDLE;
                bitcnt   <= '0;
                in_ack   <= 1'b0;
                sda_oe_o <= 1'b0;
            end else if (ph != PH_IDLE) begin
                if (ev_i.scl_rise) begin
                    if (bitcnt < LAST_BIT) begin
                        shreg  <= {shreg[BYTE_W-2:0], ev_i.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (in_ack) begin
                        nack <= ev_i.sda;
                    end
                end else if (ev_i.scl_fall) begin
                    if (bitcnt == LAST_BIT && !in_ack) begin
                        // falling edge after bit 8: enter the acknowledge slot
                        in_ack <= 1'b1;
                        case (ph)
                            PH_ADDR: begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    sda_oe_o <= 1'b1;
                                    rw       <= shreg[0];
                                end else begin
                                    ph <= PH_IDLE;
                                end
                            end
                            PH_PTR: begin
                                sda_oe_o <= 1'b1;
                                ptr      <= shreg[PTR_W-1:0];
                            end
                            PH_WR: begin
                                sda_oe_o <= 1'b1;
                                wr_en_o  <= 1'b1;
                                wr_idx_o <= ptr;
                                ptr      <= ptr + 1'b1;
                            end
                            PH_RD: begin
                                sda_oe_o <= 1'b0;
                                clr_o    <= (ptr == '0);
                                ptr      <= ptr + 1'b1;
                            end
                            default: ;
                        endcase
                    end else if (bitcnt == LAST_BIT) begin
                        // falling edge after the ninth clock: next byte
                        in_ack   <= 1'b0;
                        bitcnt   <= '0;
                        sda_oe_o <= 1'b0;
                        case (ph)
                            PH_ADDR: begin
                                if (rw) begin
                                    ph       <= PH_RD;
                                    tx       <= rd_byte_i;
                                    sda_oe_o <= ~rd_byte_i[7];
                                end else begin
                                    ph <= PH_PTR;
                                end
                            end
                            PH_PTR: ph <= PH_WR;
                            PH_RD: begin
                                if (nack) begin
                                    ph <= PH_IDLE;
                                end else begin
                                    tx       <= rd_byte_i;
                                    sda_oe_o <= ~rd_byte_i[7];
                                end
                            end
                            default: ;
                        endcase
                    end else if (ph == PH_RD && bitcnt != 4'd0) begin
                        sda_oe_o <= ~tx[BYTE_W-2];
                        tx       <= {tx[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lux_i2c_regs.sv
module lux_i2c_regs
    import lux_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_idx_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_idx_i,
    output logic [BYTE_W-1:0] rd_data_o,
    input  logic              res_vld_i,
    input  logic [15:0]       res_i,
    input  logic              flag_set_i,
    input  logic              flag_clr_i,
    output regbank_t          bank_o
);
    regbank_t bank_q;
    regbank_t bank_d;

    always_comb begin
        bank_d = bank_q;
        if (wr_en_i) begin
            bank_d = bank_write(bank_q, wr_idx_i, wr_data_i);
        end
        if (res_vld_i) begin
            bank_d.result = res_i;
        end
        if (flag_clr_i) begin
            bank_d.flag = 1'b0;
        end
        if (flag_set_i) begin
            bank_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= bank_reset();
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_data_o = bank_read(bank_q, rd_idx_i);
    assign bank_o    = bank_q;
endmodule

// File: rtl/lux_i2c_regfile.sv
module lux_i2c_regfile
    import lux_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h44,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic [15:0] result_i,
    input  logic        result_vld_i,
    input  logic        flag_set_i,
    output logic [2:0]  op_mode_o,
    output logic [1:0]  persist_o,
    output logic [1:0]  adc_res_o,
    output logic [1:0]  lux_range_o,
    output logic [15:0] thr_lo_o,
    output logic [15:0] thr_hi_o,
    output logic        irq_flag_o,
    output logic        flag_clr_o
);
    bus_ev_t           ev;
    logic [PTR_W-1:0]  ptr;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;
    logic              clr;
    regbank_t          bank;

    lux_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    lux_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .ev_i      (ev),
        .rd_byte_i (rd_data),
        .ptr_o     (ptr),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data),
        .clr_o     (clr),
        .sda_oe_o  (sda_oe_o)
    );

    lux_i2c_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_data_i  (wr_data),
        .rd_idx_i   (ptr),
        .rd_data_o  (rd_data),
        .res_vld_i  (result_vld_i),
        .res_i      (result_i),
        .flag_set_i (flag_set_i),
        .flag_clr_i (clr),
        .bank_o     (bank)
    );

    assign op_mode_o   = bank.mode;
    assign persist_o   = bank.persist;
    assign adc_res_o   = bank.res;
    assign lux_range_o = bank.rng;
    assign thr_lo_o    = bank.thr_lo;
    assign thr_hi_o    = bank.thr_hi;
    assign irq_flag_o  = bank.flag;
    assign flag_clr_o  = clr;
endmodule

// File: rtl/lux_i2c_regfile_chk.sv
module lux_i2c_regfile_chk (
    input logic        clk,
    input logic        rst,
    input logic        scl_i,
    input logic        sda_i,
    input logic        sda_oe_o,
    input logic [15:0] result_i,
    input logic        result_vld_i,
    input logic        flag_set_i,
    input logic [2:0]  op_mode_o,
    input logic [1:0]  persist_o,
    input logic [1:0]  adc_res_o,
    input logic [1:0]  lux_range_o,
    input logic [15:0] thr_lo_o,
    input logic [15:0] thr_hi_o,
    input logic        irq_flag_o,
    input logic        flag_clr_o
);
    // R10
    clr_single_chk: assert property (@(posedge clk) disable iff (rst)
        flag_clr_o |=> !flag_clr_o);

    // R10
    clr_drops_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_clr_o && !flag_set_i) |=> !irq_flag_o);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        flag_set_i |=> irq_flag_o);

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_flag_o && !flag_clr_o) |=> irq_flag_o);

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !scl_i);

    // R8
    reset_value_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (thr_hi_o == 16'hFFFF && thr_lo_o == 16'h0000 &&
                        op_mode_o == 3'd0 && !irq_flag_o && !sda_oe_o));
endmodule

bind lux_i2c_regfile lux_i2c_regfile_chk u_chk (.*);

// File: tb/lux_i2c_regfile_bench.sv
module lux_i2c_regfile_bench;
    localparam logic [6:0] DEV = 7'h44;
    localparam int H = 20;

    logic clk = 1'b0, rst = 1'b1, m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, sda_line;
    logic [15:0] result = '0;
    logic result_vld = 1'b0, flag_set = 1'b0;
    logic [2:0] op_mode;
    logic [1:0] persist, adc_res, lux_range;
    logic [15:0] thr_lo, thr_hi;
    logic irq_flag, flag_clr;

    int checks = 0, fails = 0, clr_cnt = 0;
    bit cmp_en = 1'b0, done = 1'b0;
    logic [7:0] mreg [8];
    logic [2:0] mptr = '0;
    logic prev_oe = 1'b0;

    always #5 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    lux_i2c_regfile #(.DEV_ADDR(DEV)) u_lux_i2c_regfile (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .result_i(result), .result_vld_i(result_vld), .flag_set_i(flag_set),
        .op_mode_o(op_mode), .persist_o(persist), .adc_res_o(adc_res),
        .lux_range_o(lux_range), .thr_lo_o(thr_lo), .thr_hi_o(thr_hi),
        .irq_flag_o(irq_flag), .flag_clr_o(flag_clr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reference register behaviour (R4, R5, R6, R7)
    task automatic mwrite(input logic [2:0] idx, input logic [7:0] d);
        case (idx)
            3'd0: mreg[0] = {d[7:5], 2'b00, mreg[0][2], d[1:0]};
            3'd1: mreg[1] = {4'b0000, d[3:0]};
            3'd2, 3'd3: ;
            default: mreg[idx] = d;
        endcase
    endtask

    // per-clock comparison of exported fields on an idle bus
    always @(negedge clk) begin
        if (!rst && sda_oe != prev_oe)
            chk(m_scl == 1'b0, "R11", "sda_oe changed with SCL high", m_scl, 0);
        prev_oe = sda_oe;
        if (flag_clr) clr_cnt++;
        if (cmp_en) begin
            chk(op_mode == mreg[0][7:5] && persist == mreg[0][1:0] && irq_flag == mreg[0][2],
                "R4", "reg0 fields", {op_mode, irq_flag, persist}, {mreg[0][7:5], mreg[0][2], mreg[0][1:0]});
            chk(adc_res == mreg[1][3:2] && lux_range == mreg[1][1:0],
                "R5", "reg1 fields", {adc_res, lux_range}, mreg[1][3:0]);
            chk(thr_lo == {mreg[5], mreg[4]} && thr_hi == {mreg[7], mreg[6]},
                "R7", "thresholds", {thr_hi, thr_lo}, {mreg[7], mreg[6], mreg[5], mreg[4]});
        end
    end

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wt(H);
        m_sda = 1'b0; wt(H);
        m_scl = 1'b0;
    endtask

    task automatic bus_rstart();
        wt(5); m_sda = 1'b1; wt(H - 5);
        m_scl = 1'b1; wt(H);
        m_sda = 1'b0; wt(H);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        wt(5); m_sda = 1'b0; wt(H - 5);
        m_scl = 1'b1; wt(H);
        m_sda = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            wt(5); m_sda = b[i]; wt(H - 5);
            m_scl = 1'b1; wt(H);
            m_scl = 1'b0;
        end
        wt(5); m_sda = 1'b1; wt(H - 5);
        m_scl = 1'b1; wt(H / 2);
        ack = !sda_line;
        wt(H / 2); m_scl = 1'b0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wt(H); m_scl = 1'b1; wt(H / 2);
            b[i] = sda_line;
            wt(H / 2); m_scl = 1'b0;
        end
        wt(5); m_sda = !mack; wt(H - 5);
        m_scl = 1'b1; wt(H);
        m_scl = 1'b0; wt(5); m_sda = 1'b1;
    endtask

    task automatic wr_txn(input logic [6:0] a, input logic [7:0] p, input int n,
                          input logic [31:0] d);
        bit ack;
        bit hit;
        hit = (a == DEV);
        cmp_en = 1'b0;
        bus_start();
        send_byte({a, 1'b0}, ack);
        chk(ack == hit, "R1", "address acknowledge", ack, hit);
        send_byte(p, ack);
        chk(ack == hit, "R2", "pointer acknowledge", ack, hit);
        if (hit) mptr = p[2:0];
        for (int k = 0; k < n; k++) begin
            send_byte(d[8*k +: 8], ack);
            chk(ack == hit, "R2", "data acknowledge", ack, hit);
            if (hit) begin
                mwrite(mptr, d[8*k +: 8]);
                mptr = mptr + 3'd1; // R3
            end
        end
        bus_stop();
        wt(4);
        cmp_en = 1'b1;
    endtask

    task automatic rd_txn(input bit use_ptr, input logic [7:0] p, input int n);
        bit ack;
        int c0;
        int zeros;
        logic [7:0] b;
        logic [7:0] exp;
        cmp_en = 1'b0;
        c0 = clr_cnt;
        zeros = 0;
        bus_start();
        if (use_ptr) begin
            send_byte({DEV, 1'b0}, ack);
            chk(ack, "R1", "address acknowledge", ack, 1);
            send_byte(p, ack);
            chk(ack, "R2", "pointer acknowledge", ack, 1);
            mptr = p[2:0];
            bus_rstart(); // R12
        end
        send_byte({DEV, 1'b1}, ack);
        chk(ack, "R12", "read address acknowledge", ack, 1);
        for (int k = 0; k < n; k++) begin
            exp = mreg[mptr];
            recv_byte(k != n - 1, b);
            chk(b == exp, "R9", $sformatf("read data reg%0d", mptr), b, exp);
            if (mptr == 3'd0) begin
                zeros++;
                mreg[0][2] = 1'b0;
            end
            mptr = mptr + 3'd1; // R3
        end
        bus_stop();
        wt(2);
        chk(sda_oe == 1'b0, "R9", "released after NACK", sda_oe, 0);
        chk(clr_cnt - c0 == zeros, "R10", "clear pulses", clr_cnt - c0, zeros);
        wt(4);
        cmp_en = 1'b1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) mreg[i] = (i >= 6) ? 8'hFF : 8'h00;
        wt(4);
        rst = 1'b0;
        wt(2);
        // R8 reset values at the ports
        chk(thr_hi == 16'hFFFF && thr_lo == 16'h0 && op_mode == 0 && !irq_flag && !sda_oe,
            "R8", "port reset values", {thr_hi, thr_lo}, 32'hFFFF0000);
        cmp_en = 1'b1;
        wt(10);
        // R8 reset values over the bus, R3 wrap 7 -> 0 exercised later
        rd_txn(1'b1, 8'h00, 8);
        // R4 flag bit and bits 4:3 not writable
        wr_txn(DEV, 8'h00, 1, 32'h0000_00FF);
        rd_txn(1'b1, 8'h00, 1);
        // R5 upper bits read zero
        wr_txn(DEV, 8'h01, 1, 32'h0000_00F6);
        rd_txn(1'b1, 8'h01, 1);
        // R7 and R3: four-byte write across both thresholds
        wr_txn(DEV, 8'h04, 4, 32'hC3D4_A1B2);
        rd_txn(1'b1, 8'h04, 4);
        // R3 read continues from the current pointer, wraps 7 -> 0
        rd_txn(1'b1, 8'h06, 1);
        rd_txn(1'b0, 8'h00, 2);
        // R6 captured result, bus writes ignored
        cmp_en = 1'b0;
        result = 16'hBEEF; result_vld = 1'b1; wt(1); result_vld = 1'b0;
        mreg[2] = 8'hEF; mreg[3] = 8'hBE;
        wt(2); cmp_en = 1'b1;
        wr_txn(DEV, 8'h02, 2, 32'h0000_2211);
        rd_txn(1'b1, 8'h02, 2);
        // R1 mismatching address: no acknowledge, nothing changes
        wr_txn(7'h23, 8'h04, 2, 32'h0000_5555);
        rd_txn(1'b1, 8'h04, 2);
        // R10 flag set, then read of reg 0 clears it
        cmp_en = 1'b0;
        flag_set = 1'b1; wt(1); flag_set = 1'b0;
        mreg[0][2] = 1'b1;
        wt(2); cmp_en = 1'b1;
        wt(5);
        chk(irq_flag == 1'b1, "R10", "flag set", irq_flag, 1);
        rd_txn(1'b1, 8'h00, 1);
        chk(irq_flag == 1'b0, "R10", "flag cleared by read", irq_flag, 0);
        // R2 repeated write of mode field
        wr_txn(DEV, 8'h00, 2, 32'h0000_0B41);
        rd_txn(1'b1, 8'h00, 2);
        wt(10);
        done = 1'b1;
        finish_run();
    end
endmodule